// File: doc/BRIEF.md
# CEC Frame Transmitter

This block sends one frame on a single open-drain consumer-electronics-control line. It drives the line low through `lineDriveLow` and reads the wired level back on `lineIn`. A frame begins with a start bit. Each byte that follows carries eight data bits sent most significant first, then an end-of-message bit, then an acknowledge slot. The block keeps sending bytes until it has sent one whose end-of-message flag is 1. All bit timing comes from a prescaled unit of 0.05 ms, which is `CLK_PER_UNIT` clocks long.

Software loads each byte and its end-of-message flag into a one-byte holding buffer. When the first data bit of a byte begins, the buffer contents move into the shift register and a byte-start interrupt tells software to load the next byte. A bus-idle monitor runs all the time. It counts the time since the last falling edge on the line. After software sets the enable, the frame begins as soon as that time reaches `freeBits` bit periods. If the line has already been quiet that long, the frame begins at once.

The block stops a frame and reports an error code when a directly addressed byte is not acknowledged, when the buffer is empty at a byte boundary, or when the line reads low while the block has released it. The enable clears itself when a frame ends or when an error stops it. The receive-permission output is held off for as long as a frame is in progress.

Top module: `cec_frame_tx`

## Requirements
- R1: The start bit begins only after the line has shown no falling edge for `freeBits` bit periods (48 units each). If that condition already holds when `enSet` pulses, the line goes low within 5 clocks.
- R2: The start bit is low for 74 units (3.7 ms), and the next bit starts 90 units (4.5 ms) after the start bit began.
- R3: Every bit after the start bit is 48 units long. A 0 is low for 30 units and a 1 is low for 12 units. Each byte is sent as its data bits, most significant first, then the end-of-message bit, then an acknowledge slot sent as a 1.
- R4: At the first data bit of each byte, the buffered byte moves to the shift register, `bufFull` clears, `irqByte` pulses for one clock and `statByte` is set.
- R5: After the acknowledge slot of a byte whose end-of-message flag is 1, the following happen: `irqEnd` pulses, `statEnd` is set, `txEnabled` clears and the line is released.
- R6: In the acknowledge slot the line is sampled at 21 units. A high level there stops the frame with `irqError` and `errCode` = 1 (not acknowledged).
- R7: If the buffer is empty at a byte boundary, the frame stops with `errCode` = 2 (underrun). This includes the first byte after the start bit.
- R8: If the line reads low during a released phase outside the acknowledge slot, the frame stops with `errCode` = 3. The line is released and stays released, and `txEnabled` clears.
- R9: `rxActive` follows `rxEnable` while idle and stays low whenever a frame is in progress.
- R10: The `statByte`, `statEnd`, `statError` and `errCode` outputs hold their value until `statClr` pulses, and `statClr` returns them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enSet | input | 1 | Pulse that sets the transmit enable |
| statClr | input | 1 | Pulse that clears the sticky status bits and the error code |
| bufWrite | input | 1 | Writes `bufData` and `bufEom` into the holding buffer |
| bufData | input | 8 | Byte to send |
| bufEom | input | 1 | End-of-message flag of the byte |
| freeBits | input | 4 | Number of quiet bit periods required before a start bit |
| rxEnable | input | 1 | Reception requested by software |
| lineIn | input | 1 | Sensed line level |
| lineDriveLow | output | 1 | 1 pulls the open-drain line low |
| txEnabled | output | 1 | Transmit enable; clears itself at end or on error |
| bufFull | output | 1 | Holding buffer occupied |
| rxActive | output | 1 | Reception permitted |
| irqByte | output | 1 | One-clock pulse when a byte starts |
| irqEnd | output | 1 | One-clock pulse when the frame ends |
| irqError | output | 1 | One-clock pulse when an error stops the frame |
| statByte | output | 1 | Sticky byte-start status |
| statEnd | output | 1 | Sticky end-of-frame status |
| statError | output | 1 | Sticky error status |
| errCode | output | 2 | 0 none, 1 not acknowledged, 2 underrun, 3 bus error |

## Verification
The bench sweeps frames of one to three bytes, including all-zero and all-one bytes. It times every low pulse and every bit period against the unit arithmetic. A transmitter that sent the least significant bit first, mixed up the 0 and 1 widths, or started a bit one unit late would fail the width and period comparisons. The bench also injects a falling edge just before enabling. A design whose idle monitor counted from the enable, or ignored the edge, would start early. The bench drives each error stop separately: a missing acknowledge, a buffer left empty in mid-frame, an enable with no byte loaded, and a foreign low pulse in a released phase. A design that kept driving or kept its enable after an error shows a wrong code or a stray pulse.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;
  typedef struct packed {
    logic restart;
    logic load;
    logic shift;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_NACK     = 2'd1,
    ERR_UNDERRUN = 2'd2,
    ERR_BUS      = 2'd3
  } errCode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BIT   = 2'd2
  } txState_t;
endpackage

// File: rtl/cec_tx_datapath.sv
module cec_tx_datapath
  import cec_tx_pkg::*;
#(
  parameter int CLK_PER_UNIT = 2,
  parameter int BIT_LEN_U    = 48,
  parameter int FREE_W       = 4,
  parameter int UNIT_W       = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              bufWrite,
  input  logic [7:0]        bufData,
  input  logic              bufEom,
  input  logic              lineIn,
  input  logic [FREE_W-1:0] freeBits,
  output logic              unitTick,
  output logic [UNIT_W-1:0] bitUnits,
  output logic              lineQ,
  output logic              busFree,
  output logic              bufFull,
  output logic              curBit,
  output logic [3:0]        bitIdx,
  output logic              lastEom
);
  localparam int PRE_W    = (CLK_PER_UNIT > 1) ? $clog2(CLK_PER_UNIT) : 1;
  localparam int FREE_MAX = ((1 << FREE_W) - 1) * BIT_LEN_U;
  localparam int FCNT_W   = $clog2(FREE_MAX + 1);
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(CLK_PER_UNIT - 1);
  localparam logic [UNIT_W-1:0] UNIT_MAX  = UNIT_W'((1 << UNIT_W) - 1);
  localparam logic [FCNT_W-1:0] FREE_SAT  = FCNT_W'(FREE_MAX);
  localparam logic [FCNT_W-1:0] BIT_LEN_F = FCNT_W'(BIT_LEN_U);

  logic [PRE_W-1:0]  preCnt;
  logic              linePrev;
  logic [FCNT_W-1:0] freeCnt;
  logic [FCNT_W-1:0] freeNeed;
  logic [7:0]        bufDataQ;
  logic              bufEomQ;
  logic [7:0]        shReg;
  logic              shEom;

  assign unitTick = (preCnt == PRE_LAST);

  // unit prescaler, re-phased at every bit boundary
  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart || unitTick) preCnt <= '0;
    else                                     preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart)             bitUnits <= '0;
    else if (unitTick && bitUnits != UNIT_MAX) bitUnits <= bitUnits + 1'b1;
  end

  // line sampling and bus-idle monitor
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ    <= 1'b1;
      linePrev <= 1'b1;
      freeCnt  <= '0;
    end else begin
      lineQ    <= lineIn;
      linePrev <= lineQ;
      if (linePrev && !lineQ)                  freeCnt <= '0;
      else if (unitTick && freeCnt != FREE_SAT) freeCnt <= freeCnt + 1'b1;
    end
  end

  assign freeNeed = FCNT_W'(freeBits) * BIT_LEN_F;
  assign busFree  = (freeCnt >= freeNeed);

  // holding buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufFull  <= 1'b0;
      bufDataQ <= '0;
      bufEomQ  <= 1'b0;
    end else if (bufWrite) begin
      bufFull  <= 1'b1;
      bufDataQ <= bufData;
      bufEomQ  <= bufEom;
    end else if (strobe.load) begin
      bufFull  <= 1'b0;
    end
  end

  // shift register: index 0..7 data, 8 end-of-message, 9 acknowledge slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      shEom  <= 1'b0;
      bitIdx <= '0;
    end else if (strobe.load) begin
      shReg  <= bufDataQ;
      shEom  <= bufEomQ;
      bitIdx <= '0;
    end else if (strobe.shift) begin
      shReg  <= {shReg[6:0], 1'b0};
      bitIdx <= bitIdx + 1'b1;
    end
  end

  assign lastEom = shEom;
  always_comb begin
    if (bitIdx < 4'd8)       curBit = shReg[7];
    else if (bitIdx == 4'd8) curBit = shEom;
    else                     curBit = 1'b1;
  end

  assert_load_from_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> bufFull);
  assert_index_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= 4'd9);
endmodule

// File: rtl/cec_tx_ctrl.sv
module cec_tx_ctrl
  import cec_tx_pkg::*;
#(
  parameter int START_LOW_U = 74,
  parameter int START_LEN_U = 90,
  parameter int ZERO_LOW_U  = 30,
  parameter int ONE_LOW_U   = 12,
  parameter int BIT_LEN_U   = 48,
  parameter int ACK_SMP_U   = 21,
  parameter int UNIT_W      = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enSet,
  input  logic              statClr,
  input  logic              unitTick,
  input  logic [UNIT_W-1:0] bitUnits,
  input  logic              lineQ,
  input  logic              busFree,
  input  logic              bufFull,
  input  logic              curBit,
  input  logic [3:0]        bitIdx,
  input  logic              lastEom,
  output dpStrobe_t         strobe,
  output logic              driveLow,
  output logic              busy,
  output logic              txEnabled,
  output logic              irqByte,
  output logic              irqEnd,
  output logic              irqError,
  output logic              statByte,
  output logic              statEnd,
  output logic              statError,
  output errCode_t          errCode
);
  localparam logic [UNIT_W-1:0] START_LOW_C = UNIT_W'(START_LOW_U);
  localparam logic [UNIT_W-1:0] START_CHK_C = UNIT_W'(START_LOW_U + 1);
  localparam logic [UNIT_W-1:0] START_END_C = UNIT_W'(START_LEN_U - 1);
  localparam logic [UNIT_W-1:0] ZERO_LOW_C  = UNIT_W'(ZERO_LOW_U);
  localparam logic [UNIT_W-1:0] ONE_LOW_C   = UNIT_W'(ONE_LOW_U);
  localparam logic [UNIT_W-1:0] BIT_END_C   = UNIT_W'(BIT_LEN_U - 1);
  localparam logic [UNIT_W-1:0] ACK_SMP_C   = UNIT_W'(ACK_SMP_U - 1);

  txState_t          state, nextState;
  logic              enQ;
  logic [UNIT_W-1:0] lowLen, lowChk;
  logic              ackSlot, boundary;
  logic              evByte, evEnd, evErr;
  errCode_t          errKind;

  assign ackSlot = (bitIdx == 4'd9);
  assign lowLen  = curBit ? ONE_LOW_C : ZERO_LOW_C;
  assign lowChk  = lowLen + 1'b1;

  always_comb begin
    nextState = state;
    strobe    = '0;
    evByte    = 1'b0;
    evEnd     = 1'b0;
    evErr     = 1'b0;
    errKind   = ERR_NONE;
    boundary  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (enQ && busFree) begin
          nextState      = ST_START;
          strobe.restart = 1'b1;
        end
      end
      ST_START: begin
        if (unitTick && bitUnits >= START_CHK_C && !lineQ) begin
          evErr = 1'b1; errKind = ERR_BUS;
        end else if (unitTick && bitUnits == START_END_C) begin
          boundary = 1'b1;
        end
      end
      ST_BIT: begin
        if (unitTick && !ackSlot && bitUnits >= lowChk && !lineQ) begin
          evErr = 1'b1; errKind = ERR_BUS;
        end else if (unitTick && ackSlot && bitUnits == ACK_SMP_C && lineQ) begin
          evErr = 1'b1; errKind = ERR_NACK;
        end else if (unitTick && bitUnits == BIT_END_C) begin
          if (!ackSlot) begin
            strobe.shift   = 1'b1;
            strobe.restart = 1'b1;
          end else if (lastEom) begin
            evEnd     = 1'b1;
            nextState = ST_IDLE;
          end else begin
            boundary = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
    if (boundary) begin
      if (bufFull) begin
        strobe.load    = 1'b1;
        strobe.restart = 1'b1;
        evByte         = 1'b1;
        nextState      = ST_BIT;
      end else begin
        evErr   = 1'b1;
        errKind = ERR_UNDERRUN;
      end
    end
    if (evErr) nextState = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      enQ       <= 1'b0;
      irqByte   <= 1'b0;
      irqEnd    <= 1'b0;
      irqError  <= 1'b0;
      statByte  <= 1'b0;
      statEnd   <= 1'b0;
      statError <= 1'b0;
      errCode   <= ERR_NONE;
    end else begin
      state    <= nextState;
      irqByte  <= evByte;
      irqEnd   <= evEnd;
      irqError <= evErr;
      if (enSet)               enQ <= 1'b1;
      else if (evEnd || evErr) enQ <= 1'b0;
      if (evByte)       statByte <= 1'b1;
      else if (statClr) statByte <= 1'b0;
      if (evEnd)        statEnd <= 1'b1;
      else if (statClr) statEnd <= 1'b0;
      if (evErr) begin
        statError <= 1'b1;
        errCode   <= errKind;
      end else if (statClr) begin
        statError <= 1'b0;
        errCode   <= ERR_NONE;
      end
    end
  end

  assign busy      = (state != ST_IDLE);
  assign txEnabled = enQ;
  assign driveLow  = ((state == ST_START) && (bitUnits < START_LOW_C)) ||
                     ((state == ST_BIT) && (bitUnits < lowLen));

  assert_irq_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({irqByte, irqEnd, irqError}));
  assert_end_goes_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqEnd |-> !busy && !driveLow);
  assert_error_releases_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqError |-> !driveLow && errCode != ERR_NONE);
  assert_start_after_free_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(busFree));
endmodule

// File: rtl/cec_frame_tx.sv
module cec_frame_tx
  import cec_tx_pkg::*;
#(
  parameter int CLK_PER_UNIT = 2,
  parameter int START_LOW_U  = 74,
  parameter int START_LEN_U  = 90,
  parameter int ZERO_LOW_U   = 30,
  parameter int ONE_LOW_U    = 12,
  parameter int BIT_LEN_U    = 48,
  parameter int ACK_SMP_U    = 21,
  parameter int FREE_W       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enSet,
  input  logic              statClr,
  input  logic              bufWrite,
  input  logic [7:0]        bufData,
  input  logic              bufEom,
  input  logic [FREE_W-1:0] freeBits,
  input  logic              rxEnable,
  input  logic              lineIn,
  output logic              lineDriveLow,
  output logic              txEnabled,
  output logic              bufFull,
  output logic              rxActive,
  output logic              irqByte,
  output logic              irqEnd,
  output logic              irqError,
  output logic              statByte,
  output logic              statEnd,
  output logic              statError,
  output logic [1:0]        errCode
);
  localparam int UNIT_W = $clog2(START_LEN_U + 1);

  dpStrobe_t         strobe;
  logic              unitTick, lineQ, busFree, curBit, lastEom, busy;
  logic [UNIT_W-1:0] bitUnits;
  logic [3:0]        bitIdx;
  errCode_t          errQ;

  cec_tx_datapath #(
    .CLK_PER_UNIT(CLK_PER_UNIT), .BIT_LEN_U(BIT_LEN_U),
    .FREE_W(FREE_W), .UNIT_W(UNIT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .bufWrite(bufWrite), .bufData(bufData), .bufEom(bufEom),
    .lineIn(lineIn), .freeBits(freeBits),
    .unitTick(unitTick), .bitUnits(bitUnits), .lineQ(lineQ),
    .busFree(busFree), .bufFull(bufFull), .curBit(curBit),
    .bitIdx(bitIdx), .lastEom(lastEom)
  );

  cec_tx_ctrl #(
    .START_LOW_U(START_LOW_U), .START_LEN_U(START_LEN_U),
    .ZERO_LOW_U(ZERO_LOW_U), .ONE_LOW_U(ONE_LOW_U),
    .BIT_LEN_U(BIT_LEN_U), .ACK_SMP_U(ACK_SMP_U), .UNIT_W(UNIT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .enSet(enSet), .statClr(statClr),
    .unitTick(unitTick), .bitUnits(bitUnits), .lineQ(lineQ),
    .busFree(busFree), .bufFull(bufFull), .curBit(curBit),
    .bitIdx(bitIdx), .lastEom(lastEom), .strobe(strobe),
    .driveLow(lineDriveLow), .busy(busy), .txEnabled(txEnabled),
    .irqByte(irqByte), .irqEnd(irqEnd), .irqError(irqError),
    .statByte(statByte), .statEnd(statEnd), .statError(statError),
    .errCode(errQ)
  );

  assign errCode  = errQ;
  assign rxActive = rxEnable && !busy;

  assert_no_rx_while_driving_R9: assert property (@(posedge clk) disable iff (!rstN)
    lineDriveLow |-> !rxActive);
endmodule

// File: tb/cec_frame_tx_tb_top.sv
module cec_frame_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 2;
  localparam int BITCLK     = 48 * CPU;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enSet = 1'b0, statClr = 1'b0, bufWrite = 1'b0, bufEom = 1'b0;
  logic [7:0] bufData = '0;
  logic [3:0] freeBits = 4'd1;
  logic rxEnable = 1'b1;
  logic lineIn;
  logic lineDriveLow, txEnabled, bufFull, rxActive;
  logic irqByte, irqEnd, irqError, statByte, statEnd, statError;
  logic [1:0] errCode;

  logic folPull, errPull = 1'b0, ackOn = 1'b1, recClr = 1'b0;
  int   folCnt;
  int   checks = 0, fails = 0;
  int   cyc = 0;

  int   widths [0:63];
  int   startT [0:63];
  int   nPulse, nStart, lowCnt, byteIrqs, endIrqs, errIrqs, rxViol;
  logic prevDrv;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign folPull = (folCnt != 0);
  assign lineIn  = !(lineDriveLow || folPull || errPull);

  cec_frame_tx dut_i (
    .clk(clk), .rstN(rstN), .enSet(enSet), .statClr(statClr),
    .bufWrite(bufWrite), .bufData(bufData), .bufEom(bufEom),
    .freeBits(freeBits), .rxEnable(rxEnable), .lineIn(lineIn),
    .lineDriveLow(lineDriveLow), .txEnabled(txEnabled), .bufFull(bufFull),
    .rxActive(rxActive), .irqByte(irqByte), .irqEnd(irqEnd),
    .irqError(irqError), .statByte(statByte), .statEnd(statEnd),
    .statError(statError), .errCode(errCode)
  );

  // recorder and acknowledging follower
  always @(posedge clk) begin
    cyc <= cyc + 1;
    prevDrv <= lineDriveLow;
    if (folCnt != 0) folCnt <= folCnt - 1;
    if (recClr) begin
      nPulse <= 0; nStart <= 0; lowCnt <= 0;
      byteIrqs <= 0; endIrqs <= 0; errIrqs <= 0; rxViol <= 0;
    end else begin
      if (irqByte)  byteIrqs <= byteIrqs + 1;
      if (irqEnd)   endIrqs  <= endIrqs + 1;
      if (irqError) errIrqs  <= errIrqs + 1;
      if (lineDriveLow && rxActive) rxViol <= rxViol + 1;
      if (lineDriveLow && !prevDrv) begin
        if (nStart < 64) startT[nStart] <= cyc;
        nStart <= nStart + 1;
        if (ackOn && nStart > 0 && (nStart % 10) == 0) folCnt <= 30 * CPU;
      end
      if (lineDriveLow) lowCnt <= lowCnt + 1;
      else if (lowCnt != 0) begin
        if (nPulse < 64) widths[nPulse] <= lowCnt;
        nPulse <= nPulse + 1;
        lowCnt <= 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearRec();
    @(negedge clk); recClr = 1'b1;
    @(negedge clk); recClr = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] d, input logic eom);
    @(negedge clk); bufWrite = 1'b1; bufData = d; bufEom = eom;
    @(negedge clk); bufWrite = 1'b0;
  endtask

  task automatic pulseEn(output int t);
    @(negedge clk); enSet = 1'b1; t = cyc;
    @(negedge clk); enSet = 1'b0;
  endtask

  task automatic pulseClr();
    @(negedge clk); statClr = 1'b1;
    @(negedge clk); statClr = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (endIrqs + errIrqs > 0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  // sends a frame, refilling the buffer on each byte interrupt, then checks it
  task automatic runFrame(input int n, input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2);
    logic [7:0] dat [0:2];
    int tEn, badW, badP, k, expBit, expW;
    dat[0] = d0; dat[1] = d1; dat[2] = d2;
    clearRec();
    writeByte(dat[0], n == 1);
    pulseEn(tEn);
    for (int b = 1; b < n; b++) begin
      do @(negedge clk); while (!irqByte);
      writeByte(dat[b], b == n - 1);
    end
    waitDone();
    chk(nPulse == 1 + 10 * n, "R3 pulse count", nPulse, 1 + 10 * n);
    chk(widths[0] == 74 * CPU, "R2 start low", widths[0], 74 * CPU);
    chk(startT[1] - startT[0] == 90 * CPU, "R2 start period", startT[1] - startT[0], 90 * CPU);
    badW = 0; badP = 0;
    for (int b = 0; b < n; b++) begin
      for (int j = 0; j < 10; j++) begin
        k = 1 + 10 * b + j;
        if (j < 8)       expBit = (dat[b] >> (7 - j)) & 1;
        else if (j == 8) expBit = (b == n - 1) ? 1 : 0;
        else             expBit = 1;
        expW = expBit ? 12 * CPU : 30 * CPU;
        if (widths[k] != expW) badW++;
        if (k < 10 * n && startT[k + 1] - startT[k] != BITCLK) badP++;
      end
    end
    chk(badW == 0, "R3 bit widths msb-first eom ack", badW, 0);
    chk(badP == 0, "R3 bit periods", badP, 0);
    chk(byteIrqs == n, "R4 byte interrupts", byteIrqs, n);
    chk(endIrqs == 1 && errIrqs == 0, "R5 end interrupt", endIrqs, 1);
    chk(!txEnabled && !lineDriveLow, "R5 enable cleared", txEnabled, 0);
    chk(statEnd && statByte && errCode == 0, "R10 sticky status", {statEnd, statByte}, 3);
    chk(rxViol == 0, "R9 no reception while sending", rxViol, 0);
    pulseClr();
    chk(!statEnd && !statByte && !statError, "R10 cleared", {statEnd, statByte, statError}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int tEn, tFall;
    repeat (5) @(negedge clk);
    chk(!lineDriveLow && !txEnabled && !bufFull, "R5 reset idle", lineDriveLow, 0);
    chk(errCode == 0 && !statByte && !statEnd && !statError, "R10 reset status", errCode, 0);
    chk(rxActive == 1'b1, "R9 rx follows enable when idle", rxActive, 1);
    rstN = 1'b1;
    clearRec();
    repeat (300) @(negedge clk);

    // immediate start when already free
    clearRec();
    writeByte(8'h00, 1'b1);
    pulseEn(tEn);
    repeat (8) @(negedge clk);
    chk(nStart == 1 && startT[0] - tEn >= 1 && startT[0] - tEn <= 5,
        "R1 prompt start", startT[0] - tEn, 3);
    waitDone();
    chk(endIrqs == 1, "R5 single byte end", endIrqs, 1);
    pulseClr();
    repeat (200) @(negedge clk);

    runFrame(3, 8'h00, 8'hFF, 8'h80);
    repeat (150) @(negedge clk);
    for (int p = 0; p < 6; p++) begin
      runFrame(1 + p % 3, 8'((p * 53 + 7) & 255), 8'((p * 53 + 36) & 255),
               8'((p * 53 + 65) & 255));
      repeat (150) @(negedge clk);
    end

    // bus-free wait after a foreign falling edge
    freeBits = 4'd2;
    clearRec();
    writeByte(8'h5A, 1'b1);
    @(negedge clk); errPull = 1'b1; tFall = cyc;
    repeat (2) @(negedge clk); errPull = 1'b0;
    pulseEn(tEn);
    repeat (100 * CPU + 20) @(negedge clk);
    chk(nStart == 1 && startT[0] - tFall >= 96 * CPU && startT[0] - tFall <= 96 * CPU + 12,
        "R1 wait after edge", startT[0] - tFall, 96 * CPU);
    waitDone();
    pulseClr();
    freeBits = 4'd1;
    repeat (200) @(negedge clk);

    // missing acknowledge
    ackOn = 1'b0;
    clearRec();
    writeByte(8'h3C, 1'b1);
    pulseEn(tEn);
    waitDone();
    chk(errIrqs == 1 && errCode == 1, "R6 nack code", errCode, 1);
    chk(nPulse == 11 && endIrqs == 0 && !txEnabled, "R6 stopped at ack", nPulse, 11);
    chk(statError == 1'b1, "R10 error sticky", statError, 1);
    pulseClr();
    chk(errCode == 0 && !statError, "R10 error cleared", errCode, 0);
    ackOn = 1'b1;
    repeat (200) @(negedge clk);

    // underrun mid-frame
    clearRec();
    writeByte(8'hC3, 1'b0);
    pulseEn(tEn);
    waitDone();
    chk(errCode == 2 && byteIrqs == 1 && nPulse == 11, "R7 underrun after byte", errCode, 2);
    pulseClr();
    repeat (200) @(negedge clk);

    // underrun with nothing loaded
    clearRec();
    pulseEn(tEn);
    waitDone();
    chk(errCode == 2 && byteIrqs == 0 && nPulse == 1, "R7 underrun first byte", errCode, 2);
    pulseClr();
    repeat (200) @(negedge clk);

    // foreign low in a released phase
    clearRec();
    writeByte(8'hF0, 1'b1);
    pulseEn(tEn);
    do @(negedge clk); while (nStart < 4);
    repeat (35 * CPU) @(negedge clk);
    errPull = 1'b1;
    repeat (4 * CPU) @(negedge clk);
    errPull = 1'b0;
    chk(errIrqs == 1 && errCode == 3, "R8 bus error code", errCode, 3);
    clearRec();
    repeat (300) @(negedge clk);
    chk(nStart == 0 && !lineDriveLow && !txEnabled, "R8 line stays released", nStart, 0);
    pulseClr();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule